// File: doc/BRIEF.md
# Virtual-Function Control Capability Registers

This block holds the extended configuration capability through which a physical function controls its virtual functions (VFs). It stores the live control word, the programmed VF count and the system page size. It returns fixed, parameter-set values for the initial and total VF counts, the first-VF routing offset, the VF stride, the VF device identifier and the capability header. Software reaches it through a dword-wide configuration read/write port with byte enables. Two outputs, the VF enable and the effective VF count, go to the routing logic.

The write masks of the control word, the VF count and the system page size are themselves state. Enabling VFs locks the count. Programming a count larger than the total makes VF enable read-only until a legal count is written. A separate strobe lets the device add optional supported page sizes, which also widens the set of page sizes that software may select. An asynchronous active-low reset, released synchronously inside the block, restores all defaults.

Top module: `vfcap_regfile`

## Requirements
- R1: After reset the control word is 0, the VF count is 0, the system page size is 0x0001, the supported page sizes equal SUP_PGSZ_MIN (default 0x0553), and vf_enable and vf_count are 0.
- R2: The header (dword 0), the initial/total VF pair (dword 2, initial in [15:0]), the offset/stride pair (dword 3, offset in [15:0]) and the VF device ID (dword 4, [15:0]) read back their parameter values, and writes to them have no effect.
- R3: In the control word (dword 1, bits [15:0]) only bit 0 (VF enable), bit 3 (VF memory space enable) and bit 4 (ARI hierarchy) can be written. Every other bit reads 0.
- R4: A write whose byte enable 0 is set on dword 1 and whose data bit 0 is 1 makes the VF count (dword 1, bits [31:16]) read-only.
- R5: A write whose byte enable 0 is set on dword 1 and whose data bit 0 is 0 makes all 16 bits of the VF count writable.
- R6: A write to dword 1 with byte enable 2 set and byte enable 0 clear recomputes the control mask. VF enable becomes writable only if the resulting count is at most TOTAL_VFS. Bits 3 and 4 stay writable.
- R7: When one write sets both byte enable 0 and byte enable 2 of dword 1, both fields are written through the masks held before the write. Only the R4/R5 rule is then applied, and the control mask keeps its value.
- R8: vf_enable equals control bit 0. vf_count equals the VF count while VF enable is set and is 0 otherwise.
- R9: System page size (dword 6, [15:0]) is written through a mask that equals the supported page sizes (dword 5, [15:0]).
- R10: A cycle with pgsz_add_valid ORs pgsz_add_bits into the supported page sizes, and the system page size mask follows the new value.
- R11: A write outside the seven dwords starting at CAP_BASE changes nothing, and a read there returns 0.
- R12: cfg_rd_valid is high exactly in the cycle after a cycle with cfg_rd, with cfg_rdata holding the addressed dword.
- R13: A reset in mid-operation restores every write mask: the VF count becomes writable again and VF enable becomes writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | ADDR_W | Byte address (bits [1:0] ignored) |
| cfg_be | input | 4 | Byte enables of the dword |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, registered |
| cfg_rd_valid | output | 1 | Read data valid |
| pgsz_add_valid | input | 1 | Add optional supported page sizes |
| pgsz_add_bits | input | 16 | Page-size bits to add |
| vf_enable | output | 1 | VFs enabled |
| vf_count | output | 16 | Effective number of enabled VFs |

## Verification
Several properties are checked on every cycle: the gating of vf_count by vf_enable, the one-cycle read latency, the count staying frozen while its mask is zero, the inertness of out-of-window writes, the absence of non-writable control bits, the system page size staying inside the supported set, and VF enable becoming read-only after an oversized count is written. Other behaviours only show up in the bench's sequences. These are the mask history across writes, such as a failed enable attempt that still locks the count, and the priority of the control rule when one write covers both fields. The bench also shows how masked byte merges land in read-back values and that a mid-run reset restores the masks.

// File: rtl/vfcap_pkg.sv
package vfcap_pkg;

  // Capability layout in dwords from CAP_BASE
  localparam int unsigned CAP_DWORDS = 7;
  localparam logic [2:0]  DW_HDR    = 3'd0;
  localparam logic [2:0]  DW_CTLCNT = 3'd1;
  localparam logic [2:0]  DW_VFNUM  = 3'd2;
  localparam logic [2:0]  DW_ROUTE  = 3'd3;
  localparam logic [2:0]  DW_DEVID  = 3'd4;
  localparam logic [2:0]  DW_SUPPG  = 3'd5;
  localparam logic [2:0]  DW_SYSPG  = 3'd6;

  // Control word bits
  localparam logic [15:0] CTL_VFE = 16'h0001;
  localparam logic [15:0] CTL_MSE = 16'h0008;
  localparam logic [15:0] CTL_ARI = 16'h0010;
  localparam logic [15:0] CTL_ALL = CTL_VFE | CTL_MSE | CTL_ARI;

  typedef struct packed {
    logic       hit;        // address inside the capability
    logic [2:0] dw;         // dword index inside the capability
    logic       ctrl_touch; // write covers the control low byte
    logic       cnt_touch;  // write covers count low byte, not control
  } vfcap_dec_t;

  // Merge a 16-bit field through a write mask and two byte enables
  function automatic logic [15:0] merge16(input logic [15:0] old_v,
                                          input logic [15:0] new_v,
                                          input logic [15:0] wmask,
                                          input logic [1:0]  be);
    logic [15:0] m;
    m = wmask & {{8{be[1]}}, {8{be[0]}}};
    return (old_v & ~m) | (new_v & m);
  endfunction

endpackage

// File: rtl/vfcap_decode.sv
module vfcap_decode
  import vfcap_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned CAP_BASE = 12'h160
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        be,
  output vfcap_dec_t        dec
);

  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(CAP_BASE);
  localparam logic [ADDR_W-1:0] WIN_A  = ADDR_W'(CAP_DWORDS * 4);

  logic [ADDR_W-1:0] off;
  logic              ctl_dw_wr;

  always_comb begin
    off            = addr - BASE_A;
    dec.hit        = (addr >= BASE_A) && (off < WIN_A);
    dec.dw         = off[4:2];
    ctl_dw_wr      = wr && dec.hit && (dec.dw == DW_CTLCNT);
    // control check wins when one access covers both fields
    dec.ctrl_touch = ctl_dw_wr && be[0];
    dec.cnt_touch  = ctl_dw_wr && be[2] && !be[0];
  end

endmodule

// File: rtl/vfcap_wmask.sv
module vfcap_wmask
  import vfcap_pkg::*;
#(
  parameter int unsigned TOTAL_VFS    = 8,
  parameter logic [15:0] SUP_PGSZ_MIN = 16'h0553
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_touch,
  input  logic        ctrl_vfe_data,
  input  logic        cnt_touch,
  input  logic [15:0] cnt_next,
  input  logic        pgsz_add_valid,
  input  logic [15:0] pgsz_add_bits,
  output logic [15:0] ctrl_wmask,
  output logic [15:0] cnt_wmask,
  output logic [15:0] sup_pgsz,
  output logic [15:0] sys_wmask
);

  localparam logic [15:0] TOTAL_W = 16'(TOTAL_VFS);

  logic [15:0] ctrl_wmask_d, cnt_wmask_d, sup_d;
  logic        ctrl_en, cnt_en, sup_en;

  always_comb begin
    ctrl_en      = cnt_touch;
    ctrl_wmask_d = CTL_MSE | CTL_ARI | ((cnt_next <= TOTAL_W) ? CTL_VFE : 16'h0);
    cnt_en       = ctrl_touch;
    cnt_wmask_d  = ctrl_vfe_data ? 16'h0000 : 16'hFFFF;
    sup_en       = pgsz_add_valid;
    sup_d        = sup_pgsz | pgsz_add_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_wmask <= CTL_ALL;
      cnt_wmask  <= 16'hFFFF;
      sup_pgsz   <= SUP_PGSZ_MIN;
      sys_wmask  <= SUP_PGSZ_MIN;
    end else begin
      if (ctrl_en) ctrl_wmask <= ctrl_wmask_d;
      if (cnt_en)  cnt_wmask  <= cnt_wmask_d;
      if (sup_en) begin
        sup_pgsz  <= sup_d;
        sys_wmask <= sup_d;
      end
    end
  end

endmodule

// File: rtl/vfcap_store.sv
module vfcap_store
  import vfcap_pkg::*;
#(
  parameter logic [31:0] CAP_HDR   = 32'h0001_0010,
  parameter int unsigned INIT_VFS  = 4,
  parameter int unsigned TOTAL_VFS = 8,
  parameter int unsigned VF_OFFSET = 1,
  parameter int unsigned VF_STRIDE = 1,
  parameter logic [15:0] VF_DEVID  = 16'h10CA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic        rd,
  input  vfcap_dec_t  dec,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  input  logic [15:0] ctrl_wmask,
  input  logic [15:0] cnt_wmask,
  input  logic [15:0] sys_wmask,
  input  logic [15:0] sup_pgsz,
  output logic [15:0] ctrl_q,
  output logic [15:0] cnt_q,
  output logic [15:0] syspg_q,
  output logic [15:0] cnt_next,
  output logic [31:0] rdata,
  output logic        rd_valid
);

  logic        ctl_wr, sys_wr;
  logic [15:0] ctrl_d, syspg_d;
  logic [31:0] rd_mux;

  always_comb begin
    ctl_wr   = wr && dec.hit && (dec.dw == DW_CTLCNT);
    sys_wr   = wr && dec.hit && (dec.dw == DW_SYSPG);
    ctrl_d   = merge16(ctrl_q,  wdata[15:0],  ctrl_wmask, be[1:0]);
    cnt_next = merge16(cnt_q,   wdata[31:16], cnt_wmask,  be[3:2]);
    syspg_d  = merge16(syspg_q, wdata[15:0],  sys_wmask,  be[1:0]);
  end

  always_comb begin
    rd_mux = 32'h0;
    if (dec.hit) begin
      unique case (dec.dw)
        DW_HDR:    rd_mux = CAP_HDR;
        DW_CTLCNT: rd_mux = {cnt_q, ctrl_q};
        DW_VFNUM:  rd_mux = {16'(TOTAL_VFS), 16'(INIT_VFS)};
        DW_ROUTE:  rd_mux = {16'(VF_STRIDE), 16'(VF_OFFSET)};
        DW_DEVID:  rd_mux = {16'h0, VF_DEVID};
        DW_SUPPG:  rd_mux = {16'h0, sup_pgsz};
        DW_SYSPG:  rd_mux = {16'h0, syspg_q};
        default:   rd_mux = 32'h0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= 16'h0;
      cnt_q    <= 16'h0;
      syspg_q  <= 16'h0001;
      rdata    <= 32'h0;
      rd_valid <= 1'b0;
    end else begin
      if (ctl_wr) begin
        ctrl_q <= ctrl_d;
        cnt_q  <= cnt_next;
      end
      if (sys_wr) syspg_q <= syspg_d;
      if (rd)     rdata   <= rd_mux;
      rd_valid <= rd;
    end
  end

endmodule

// File: rtl/vfcap_regfile.sv
module vfcap_regfile
  import vfcap_pkg::*;
#(
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned CAP_BASE     = 12'h160,
  parameter logic [31:0] CAP_HDR      = 32'h0001_0010,
  parameter int unsigned INIT_VFS     = 4,
  parameter int unsigned TOTAL_VFS    = 8,
  parameter int unsigned VF_OFFSET    = 1,
  parameter int unsigned VF_STRIDE    = 1,
  parameter logic [15:0] VF_DEVID     = 16'h10CA,
  parameter logic [15:0] SUP_PGSZ_MIN = 16'h0553
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              cfg_rd_valid,
  input  logic              pgsz_add_valid,
  input  logic [15:0]       pgsz_add_bits,
  output logic              vf_enable,
  output logic [15:0]       vf_count
);

  logic        rst_meta_n, rst_sync_n;
  vfcap_dec_t  dec;
  logic [15:0] ctrl_wmask, cnt_wmask, sup_pgsz, sys_wmask;
  logic [15:0] ctrl_q, cnt_q, syspg_q, cnt_next;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  vfcap_decode #(.ADDR_W(ADDR_W), .CAP_BASE(CAP_BASE)) u_dec (
    .wr   (cfg_wr),
    .addr (cfg_addr),
    .be   (cfg_be),
    .dec  (dec)
  );

  vfcap_wmask #(.TOTAL_VFS(TOTAL_VFS), .SUP_PGSZ_MIN(SUP_PGSZ_MIN)) u_wmask (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .ctrl_touch     (dec.ctrl_touch),
    .ctrl_vfe_data  (cfg_wdata[0]),
    .cnt_touch      (dec.cnt_touch),
    .cnt_next       (cnt_next),
    .pgsz_add_valid (pgsz_add_valid),
    .pgsz_add_bits  (pgsz_add_bits),
    .ctrl_wmask     (ctrl_wmask),
    .cnt_wmask      (cnt_wmask),
    .sup_pgsz       (sup_pgsz),
    .sys_wmask      (sys_wmask)
  );

  vfcap_store #(
    .CAP_HDR(CAP_HDR), .INIT_VFS(INIT_VFS), .TOTAL_VFS(TOTAL_VFS),
    .VF_OFFSET(VF_OFFSET), .VF_STRIDE(VF_STRIDE), .VF_DEVID(VF_DEVID)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr         (cfg_wr),
    .rd         (cfg_rd),
    .dec        (dec),
    .be         (cfg_be),
    .wdata      (cfg_wdata),
    .ctrl_wmask (ctrl_wmask),
    .cnt_wmask  (cnt_wmask),
    .sys_wmask  (sys_wmask),
    .sup_pgsz   (sup_pgsz),
    .ctrl_q     (ctrl_q),
    .cnt_q      (cnt_q),
    .syspg_q    (syspg_q),
    .cnt_next   (cnt_next),
    .rdata      (cfg_rdata),
    .rd_valid   (cfg_rd_valid)
  );

  always_comb begin
    vf_enable = ctrl_q[0];
    vf_count  = vf_enable ? cnt_q : 16'h0;
  end

endmodule

// File: rtl/vfcap_checker.sv
module vfcap_checker #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned CAP_BASE  = 12'h160,
  parameter int unsigned TOTAL_VFS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic              cfg_rd,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [3:0]        cfg_be,
  input logic              cfg_rd_valid,
  input logic              pgsz_add_valid,
  input logic [15:0]       pgsz_add_bits,
  input logic              vf_enable,
  input logic [15:0]       vf_count,
  input logic [15:0]       ctrl_q,
  input logic [15:0]       cnt_q,
  input logic [15:0]       syspg_q,
  input logic [15:0]       sup_pgsz,
  input logic [15:0]       ctrl_wmask,
  input logic [15:0]       cnt_wmask
);

  localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(CAP_BASE);
  localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(CAP_BASE + 28);

  logic in_win, cnt_only_wr, cnt_only_wr_q;

  always_comb begin
    in_win      = (cfg_addr >= LO_A) && (cfg_addr < HI_A);
    cnt_only_wr = cfg_wr && in_win && (cfg_addr[4:2] == ((3'(CAP_BASE >> 2)) + 3'd1))
                  && cfg_be[2] && !cfg_be[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_only_wr_q <= 1'b0;
    else        cnt_only_wr_q <= cnt_only_wr;
  end

  a_r8_count_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !vf_enable |-> (vf_count == 16'h0));

  a_r12_rd_latency: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd |=> cfg_rd_valid);

  a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rd |=> !cfg_rd_valid);

  a_r4_count_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wmask == 16'h0) |=> $stable(cnt_q));

  a_r11_outside_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !in_win) |=> ($stable(ctrl_q) && $stable(cnt_q) && $stable(syspg_q)));

  a_r3_ctrl_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q & 16'hFFE6) == 16'h0);

  a_r6_vfe_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_only_wr_q && (cnt_q > 16'(TOTAL_VFS))) |-> !ctrl_wmask[0]);

  a_r9_syspg_supported: assert property (@(posedge clk) disable iff (!rst_n)
    (syspg_q & ~sup_pgsz) == 16'h0);

  a_r10_sup_grows: assert property (@(posedge clk) disable iff (!rst_n)
    pgsz_add_valid |=> ((sup_pgsz & $past(pgsz_add_bits)) == $past(pgsz_add_bits)));

endmodule

bind vfcap_regfile vfcap_checker #(
  .ADDR_W(ADDR_W), .CAP_BASE(CAP_BASE), .TOTAL_VFS(TOTAL_VFS)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .cfg_wr         (cfg_wr),
  .cfg_rd         (cfg_rd),
  .cfg_addr       (cfg_addr),
  .cfg_be         (cfg_be),
  .cfg_rd_valid   (cfg_rd_valid),
  .pgsz_add_valid (pgsz_add_valid),
  .pgsz_add_bits  (pgsz_add_bits),
  .vf_enable      (vf_enable),
  .vf_count       (vf_count),
  .ctrl_q         (ctrl_q),
  .cnt_q          (cnt_q),
  .syspg_q        (syspg_q),
  .sup_pgsz       (sup_pgsz),
  .ctrl_wmask     (ctrl_wmask),
  .cnt_wmask      (cnt_wmask)
);

// File: tb/test_vfcap_regfile.sv
module test_vfcap_regfile;

  localparam logic [11:0] A_HDR = 12'h160, A_CTL = 12'h164, A_NUM = 12'h168,
                          A_RTE = 12'h16C, A_DID = 12'h170, A_SUP = 12'h174,
                          A_SYS = 12'h178, A_LOW = 12'h15C, A_HIGH = 12'h17C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_rd_valid;
  logic        pgsz_add_valid = 1'b0;
  logic [15:0] pgsz_add_bits = '0;
  logic        vf_enable;
  logic [15:0] vf_count;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct { logic [31:0] data; string tag; } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk; // 125 MHz

  vfcap_regfile i_vfcap_regfile (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_rd_valid(cfg_rd_valid),
    .pgsz_add_valid(pgsz_add_valid), .pgsz_add_bits(pgsz_add_bits),
    .vf_enable(vf_enable), .vf_count(vf_count)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares read results against the scoreboard queue
  always @(negedge clk) begin
    if (cfg_rd_valid) begin
      if (exp_q.size() == 0) check(32'h1, 32'h0, "R12 unexpected read data");
      else begin
        exp_t e;
        e = exp_q.pop_front();
        check(cfg_rdata, e.data, e.tag);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_be = be; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    exp_t e;
    @(negedge clk);
    e.data = exp; e.tag = tag;
    exp_q.push_back(e);
    cfg_addr = a; cfg_rd = 1'b1;
    @(negedge clk);
    cfg_rd = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic outputs(input logic en, input logic [15:0] cnt, input string tag);
    check({31'h0, vf_enable}, {31'h0, en}, {tag, " vf_enable"});
    check({16'h0, vf_count}, {16'h0, cnt}, {tag, " vf_count"});
  endtask

  initial begin
    do_reset();
    // R1 reset state
    check({31'h0, cfg_rd_valid}, 32'h0, "R12 idle valid");
    outputs(1'b0, 16'h0, "R1");
    rd(A_CTL, 32'h0000_0000, "R1 control/count");
    rd(A_SYS, 32'h0000_0001, "R1 system page size");
    rd(A_SUP, 32'h0000_0553, "R1 supported pages");
    // R2 fixed fields
    rd(A_HDR, 32'h0001_0010, "R2 header");
    rd(A_NUM, 32'h0008_0004, "R2 initial/total");
    rd(A_RTE, 32'h0001_0001, "R2 offset/stride");
    rd(A_DID, 32'h0000_10CA, "R2 device id");
    wr(A_NUM, 32'hFFFF_FFFF, 4'hF);
    wr(A_DID, 32'hFFFF_FFFF, 4'hF);
    rd(A_NUM, 32'h0008_0004, "R2 initial/total after write");
    rd(A_DID, 32'h0000_10CA, "R2 device id after write");
    // R3 only three control bits; VFE clear unlocks count (R5)
    wr(A_CTL, 32'h0000_FFFE, 4'b0011);
    rd(A_CTL, 32'h0000_0018, "R3 control writable bits");
    wr(A_CTL, 32'h0005_0000, 4'b1100);
    rd(A_CTL, 32'h0005_0018, "R5 count written");
    outputs(1'b0, 16'h0, "R8 disabled");
    // R4 enable locks count
    wr(A_CTL, 32'h0000_0001, 4'b0001);
    outputs(1'b1, 16'h5, "R8 enabled");
    wr(A_CTL, 32'h0007_0000, 4'b1100);
    rd(A_CTL, 32'h0005_0001, "R4 count locked");
    outputs(1'b1, 16'h5, "R4 count locked");
    // R5 disable unlocks; R6 oversized count blocks enable
    wr(A_CTL, 32'h0000_0000, 4'b0001);
    outputs(1'b0, 16'h0, "R8 disabled again");
    wr(A_CTL, 32'h0009_0000, 4'b1100);
    wr(A_CTL, 32'h0000_0019, 4'b0001);
    rd(A_CTL, 32'h0009_0018, "R6 enable masked");
    outputs(1'b0, 16'h0, "R6 enable masked");
    wr(A_CTL, 32'h0003_0000, 4'b1100);
    rd(A_CTL, 32'h0009_0018, "R4 locked by failed enable");
    wr(A_CTL, 32'h0000_0000, 4'b0001);
    wr(A_CTL, 32'h0003_0000, 4'b1100);
    wr(A_CTL, 32'h0000_0001, 4'b0001);
    outputs(1'b1, 16'h3, "R6 legal count enables");
    // R7 control rule wins on combined write
    wr(A_CTL, 32'h0000_0000, 4'b0001);
    wr(A_CTL, 32'h0009_0000, 4'b1100);
    wr(A_CTL, 32'h0002_0001, 4'b0101);
    rd(A_CTL, 32'h0002_0000, "R7 combined write");
    wr(A_CTL, 32'h0000_0001, 4'b0001);
    outputs(1'b0, 16'h0, "R7 control mask kept");
    // R9, R10 page sizes
    wr(A_SYS, 32'hFFFF_FFFF, 4'hF);
    rd(A_SYS, 32'h0000_0553, "R9 system page mask");
    @(negedge clk);
    pgsz_add_valid = 1'b1; pgsz_add_bits = 16'h0004;
    @(negedge clk);
    pgsz_add_valid = 1'b0;
    rd(A_SUP, 32'h0000_0557, "R10 supported grows");
    wr(A_SYS, 32'h0000_0004, 4'b0011);
    rd(A_SYS, 32'h0000_0004, "R10 new size selectable");
    // R11 outside window
    wr(A_LOW, 32'hFFFF_FFFF, 4'hF);
    wr(A_HIGH, 32'hFFFF_FFFF, 4'hF);
    rd(A_LOW, 32'h0, "R11 read below window");
    rd(A_HIGH, 32'h0, "R11 read above window");
    rd(A_CTL, 32'h0002_0000, "R11 control unchanged");
    rd(A_SYS, 32'h0000_0004, "R11 system page unchanged");
    // R13 reset restores masks
    do_reset();
    rd(A_CTL, 32'h0, "R13 control cleared");
    rd(A_SYS, 32'h0000_0001, "R13 system page default");
    rd(A_SUP, 32'h0000_0553, "R13 supported default");
    wr(A_CTL, 32'h0002_0000, 4'b1100);
    wr(A_CTL, 32'h0000_0001, 4'b0001);
    outputs(1'b1, 16'h2, "R13 masks restored");
    repeat (3) @(negedge clk);
    check(exp_q.size(), 32'h0, "R12 all reads returned");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule